// File: doc/BRIEF.md
# Interleaved Carrier PWM with Sample Scheduling

This block drives the two series switches of a three-level boost stage. It runs two triangular carriers of the same period, half a period apart. It compares each carrier with its own duty command to form the two gate signals. Each carrier is an up/down counter that sweeps from 0 to a half-period count `HALF_P` and back. With the default settings and a 250 MHz clock this gives a 20 kHz switching period. Carrier B starts at its peak while carrier A sits at its valley, so their sum is always `HALF_P`.

Within every switching period the block also times the current measurements for an external converter interface:

- an average-current strobe at the peak of carrier A;
- a first balance strobe where carrier A, climbing from its valley, reaches half amplitude;
- a second balance strobe where carrier A, coming down from the peak, reaches half amplitude.

A command-update strobe marks the valley of carrier A. New duty commands take effect only at that valley, after all three samples of the period have been taken. The commands pass through a shadow stage, so a command that changes mid-period cannot disturb the period in progress. Full scale for a command equals `HALF_P`; any larger value is treated as full scale.

Top module: `ilv_pwm_sched`

## Requirements
- R1: While reset is high, every gate and strobe output is 0. The first command-update strobe appears in the first cycle after reset is released.
- R2: Command-update strobes repeat every 2*HALF_P clock cycles.
- R3: Counting from the cycle in which the command-update strobe is high (offset 0), the strobes follow a fixed schedule:
  - the first balance strobe at offset HALF_P/2;
  - the average-current strobe at offset HALF_P;
  - the second balance strobe at offset 3*HALF_P/2.
- R4: Each strobe is high for exactly one cycle, and no two strobes are ever high in the same cycle.
- R5: For a command c with 0 < c < HALF_P, the gate is high in exactly 2c-1 of the 2*HALF_P cycles that start at a command-update strobe.
- R6: A command of 0 keeps its gate low for the whole period.
- R7: A command of HALF_P or more keeps its gate high for the whole period.
- R8: The commands used in a period are the input values held for at least three cycles before that period's command-update strobe. Any value presented mid-period and then replaced before that point has no effect on any gate.
- R9: The two carriers are interleaved by half a period, which fixes the gates at two points of the period:
  - In the update-strobe cycle, gate A is high exactly when its command is above 0, and gate B is high only when its command is at full scale.
  - In the average-strobe cycle, gate B is high exactly when its command is above 0, and gate A is high only when its command is at full scale.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| duty_a_i | input | CMD_W | Duty command for switch A, full scale = HALF_P |
| duty_b_i | input | CMD_W | Duty command for switch B, full scale = HALF_P |
| gate_a_o | output | 1 | Gate drive for switch A, from carrier A |
| gate_b_o | output | 1 | Gate drive for switch B, from carrier B |
| smp_avg_o | output | 1 | Average-current sample strobe (carrier A peak) |
| smp_bal1_o | output | 1 | First balance sample strobe (carrier A rising, half amplitude) |
| smp_bal2_o | output | 1 | Second balance sample strobe (carrier A falling, half amplitude) |
| cmd_upd_o | output | 1 | Command-update strobe (carrier A valley) |

## Verification
The hardest case to reach from the ports is the shadow-to-active hand-over: a value that appears only mid-period must never reach a gate. To show this, the stimulus writes a random throw-away command early in each period and replaces it after the peak with the value meant for the next period. The gate high-time in the current period and in the next one then shows which value was loaded. Directed periods cover zero commands, exact full scale and commands above full scale. Random periods between them sweep the remaining range, so the interleave points of both gates are checked with every mix of commands.

// File: rtl/ilv_pkg.sv
package ilv_pkg;
  typedef enum logic {
    SLOPE_UP = 1'b0,
    SLOPE_DN = 1'b1
  } slope_e;

  typedef struct packed {
    logic upd;
    logic bal1;
    logic avg;
    logic bal2;
  } strobe_t;
endpackage

// File: rtl/ilv_carrier.sv
module ilv_carrier #(
  parameter int HALF_P     = 6250,
  parameter int CNT_W      = 13,
  parameter bit START_PEAK = 1'b0
) (
  input  logic                 clk,
  input  logic                 rst,
  output logic [CNT_W-1:0]     cnt,
  output ilv_pkg::slope_e      slope
);
  import ilv_pkg::*;

  localparam logic [CNT_W-1:0] TOP = CNT_W'(HALF_P);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt   <= START_PEAK ? TOP : '0;
      slope <= START_PEAK ? SLOPE_DN : SLOPE_UP;
    end else if (slope == SLOPE_UP) begin
      if (cnt == TOP - 1'b1) slope <= SLOPE_DN;
      cnt <= cnt + 1'b1;
    end else begin
      if (cnt == {{(CNT_W-1){1'b0}}, 1'b1}) slope <= SLOPE_UP;
      cnt <= cnt - 1'b1;
    end
  end
endmodule

// File: rtl/ilv_sched.sv
module ilv_sched #(
  parameter int HALF_P = 6250,
  parameter int CNT_W  = 13
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [CNT_W-1:0]   cnt_a,
  input  ilv_pkg::slope_e    slope_a,
  input  logic [CNT_W-1:0]   cnt_b,
  input  ilv_pkg::slope_e    slope_b,
  output ilv_pkg::strobe_t   strb,
  output logic               load
);
  import ilv_pkg::*;

  localparam logic [CNT_W-1:0] TOP = CNT_W'(HALF_P);
  localparam logic [CNT_W-1:0] MID = CNT_W'(HALF_P / 2);

  // Carrier B one step below its peak while rising is the same instant as
  // carrier A one step above its valley while falling.
  assign load = (slope_b == SLOPE_UP) && (cnt_b == TOP - 1'b1);

  always_ff @(posedge clk) begin
    if (rst) begin
      strb <= '0;
    end else begin
      strb.upd  <= (cnt_a == '0);
      strb.bal1 <= (cnt_a == MID) && (slope_a == SLOPE_UP);
      strb.avg  <= (cnt_a == TOP);
      strb.bal2 <= (cnt_a == MID) && (slope_a == SLOPE_DN);
    end
  end
endmodule

// File: rtl/ilv_gate.sv
module ilv_gate #(
  parameter int HALF_P = 6250,
  parameter int CNT_W  = 13,
  parameter int CMD_W  = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               load,
  input  logic [CMD_W-1:0]   cmd_in,
  input  logic [CNT_W-1:0]   carrier,
  output logic               gate
);
  localparam int XW = (CMD_W > CNT_W) ? CMD_W : CNT_W;

  logic [CMD_W-1:0] shadow;
  logic [CMD_W-1:0] active;
  logic [XW-1:0]    act_x;
  logic [XW-1:0]    car_x;
  logic             full;

  assign act_x = XW'(active);
  assign car_x = XW'(carrier);
  assign full  = (act_x >= XW'(HALF_P));

  always_ff @(posedge clk) begin
    if (rst) begin
      shadow <= '0;
      active <= '0;
      gate   <= 1'b0;
    end else begin
      shadow <= cmd_in;
      if (load) active <= shadow;
      gate <= full | (act_x > car_x);
    end
  end
endmodule

// File: rtl/ilv_pwm_sched.sv
module ilv_pwm_sched #(
  parameter int HALF_P = 6250,
  parameter int CMD_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CMD_W-1:0]  duty_a_i,
  input  logic [CMD_W-1:0]  duty_b_i,
  output logic              gate_a_o,
  output logic              gate_b_o,
  output logic              smp_avg_o,
  output logic              smp_bal1_o,
  output logic              smp_bal2_o,
  output logic              cmd_upd_o
);
  import ilv_pkg::*;

  localparam int NCAR  = 2;
  localparam int CNT_W = $clog2(HALF_P + 1);

  logic [CNT_W-1:0] car_cnt   [NCAR];
  slope_e           car_slope [NCAR];
  logic [CMD_W-1:0] duty_arr  [NCAR];
  logic             gate_arr  [NCAR];
  logic             load;
  strobe_t          strb;

  assign duty_arr[0] = duty_a_i;
  assign duty_arr[1] = duty_b_i;

  for (genvar g = 0; g < NCAR; g++) begin : g_leg
    ilv_carrier #(
      .HALF_P    (HALF_P),
      .CNT_W     (CNT_W),
      .START_PEAK(g == 1)
    ) u_car (
      .clk  (clk),
      .rst  (rst),
      .cnt  (car_cnt[g]),
      .slope(car_slope[g])
    );

    ilv_gate #(
      .HALF_P(HALF_P),
      .CNT_W (CNT_W),
      .CMD_W (CMD_W)
    ) u_gate (
      .clk    (clk),
      .rst    (rst),
      .load   (load),
      .cmd_in (duty_arr[g]),
      .carrier(car_cnt[g]),
      .gate   (gate_arr[g])
    );
  end

  ilv_sched #(
    .HALF_P(HALF_P),
    .CNT_W (CNT_W)
  ) u_sched (
    .clk    (clk),
    .rst    (rst),
    .cnt_a  (car_cnt[0]),
    .slope_a(car_slope[0]),
    .cnt_b  (car_cnt[1]),
    .slope_b(car_slope[1]),
    .strb   (strb),
    .load   (load)
  );

  assign gate_a_o   = gate_arr[0];
  assign gate_b_o   = gate_arr[1];
  assign smp_avg_o  = strb.avg;
  assign smp_bal1_o = strb.bal1;
  assign smp_bal2_o = strb.bal2;
  assign cmd_upd_o  = strb.upd;
endmodule

// File: rtl/ilv_pwm_chk.sv
module ilv_pwm_chk #(
  parameter int HALF_P = 6250,
  parameter int CNT_W  = 13
) (
  input logic             clk,
  input logic             rst,
  input logic [CNT_W-1:0] cnt_a,
  input logic [CNT_W-1:0] cnt_b,
  input logic             smp_avg_o,
  input logic             smp_bal1_o,
  input logic             smp_bal2_o,
  input logic             cmd_upd_o
);
  logic any_strb;
  assign any_strb = smp_avg_o | smp_bal1_o | smp_bal2_o | cmd_upd_o;

  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (rst)
    $onehot0({smp_avg_o, smp_bal1_o, smp_bal2_o, cmd_upd_o})); // R4
  AST_STROBE_PULSE: assert property (@(posedge clk) disable iff (rst)
    any_strb |=> !any_strb); // R4
  AST_CARRIER_SUM: assert property (@(posedge clk) disable iff (rst)
    (int'(cnt_a) + int'(cnt_b)) == HALF_P); // R9
  AST_CARRIER_RANGE: assert property (@(posedge clk) disable iff (rst)
    int'(cnt_a) <= HALF_P); // R2
  AST_AVG_AT_PEAK: assert property (@(posedge clk) disable iff (rst)
    smp_avg_o |-> (int'(cnt_a) == HALF_P - 1)); // R3
  AST_UPD_AT_VALLEY: assert property (@(posedge clk) disable iff (rst)
    cmd_upd_o |-> (int'(cnt_a) == 1)); // R3
endmodule

bind ilv_pwm_sched ilv_pwm_chk #(
  .HALF_P(HALF_P),
  .CNT_W ($clog2(HALF_P + 1))
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .cnt_a     (car_cnt[0]),
  .cnt_b     (car_cnt[1]),
  .smp_avg_o (smp_avg_o),
  .smp_bal1_o(smp_bal1_o),
  .smp_bal2_o(smp_bal2_o),
  .cmd_upd_o (cmd_upd_o)
);

// File: tb/ilv_pwm_sched_bench.sv
module ilv_pwm_sched_bench;
  localparam int HP = 16;
  localparam int CW = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [CW-1:0] da  = '0;
  logic [CW-1:0] db  = '0;
  logic gate_a_o, gate_b_o, smp_avg_o, smp_bal1_o, smp_bal2_o, cmd_upd_o;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  ilv_pwm_sched #(.HALF_P(HP), .CMD_W(CW)) u_ilv_pwm_sched (
    .clk(clk), .rst(rst), .duty_a_i(da), .duty_b_i(db),
    .gate_a_o(gate_a_o), .gate_b_o(gate_b_o), .smp_avg_o(smp_avg_o),
    .smp_bal1_o(smp_bal1_o), .smp_bal2_o(smp_bal2_o), .cmd_upd_o(cmd_upd_o)
  );

  function automatic int exp_hi(int c);
    if (c == 0) return 0;
    if (c >= HP) return 2 * HP;
    return 2 * c - 1;
  endfunction

  function automatic string cnt_req(int c);
    if (c == 0) return "R6";
    if (c >= HP) return "R7";
    return "R5";
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_up();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  // Entered at the negedge where the update strobe is visible (offset 0).
  // ea/eb: commands active this period; ja/jb: throw-away mid-period values;
  // na/nb: values for the next period.
  task automatic run_period(int ea, int eb, int ja, int jb, int na, int nb);
    int ca = 0, cb = 0, bad = 0, multi = 0;
    logic [3:0] sv, ev;
    for (int i = 0; i < 2 * HP; i++) begin
      if (i > 0) @(negedge clk);
      ca += int'(gate_a_o);
      cb += int'(gate_b_o);
      sv = {cmd_upd_o, smp_bal1_o, smp_avg_o, smp_bal2_o};
      ev = (i == 0) ? 4'b1000 : (i == HP / 2) ? 4'b0100 :
           (i == HP) ? 4'b0010 : (i == 3 * HP / 2) ? 4'b0001 : 4'b0000;
      if (sv != ev) bad++;
      if ($countones(sv) > 1) multi++;
      if (i == 0) begin
        chk(gate_a_o == (ea > 0), "R9 gate A at update", int'(gate_a_o), int'(ea > 0));
        chk(gate_b_o == (eb >= HP), "R9 gate B at update", int'(gate_b_o), int'(eb >= HP));
      end
      if (i == HP) begin
        chk(gate_b_o == (eb > 0), "R9 gate B at avg", int'(gate_b_o), int'(eb > 0));
        chk(gate_a_o == (ea >= HP), "R9 gate A at avg", int'(gate_a_o), int'(ea >= HP));
      end
      if (i == 2) begin da = CW'(ja); db = CW'(jb); end
      if (i == HP + 1) begin da = CW'(na); db = CW'(nb); end
    end
    chk(bad == 0, "R3 strobe schedule mismatches", bad, 0);
    chk(multi == 0, "R4 overlapping strobes", multi, 0);
    chk(ca == exp_hi(ea), {cnt_req(ea), "/R8 gate A high count"}, ca, exp_hi(ea));
    chk(cb == exp_hi(eb), {cnt_req(eb), "/R8 gate B high count"}, cb, exp_hi(eb));
    @(negedge clk);
    chk(cmd_upd_o == 1'b1, "R2 update strobe after 2*HALF_P", int'(cmd_upd_o), 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired");
    finish_up();
  end

  initial begin
    int dir_a[8] = '{0, HP, HP + 5, 1, HP / 2, HP - 1, 0, 255};
    int dir_b[8] = '{HP, 0, 1, HP - 1, HP / 2, HP + 9, 0, 2};
    int pa, pb, na, nb, ja, jb;
    void'($urandom(32'd20250));
    repeat (5) @(negedge clk);
    chk({gate_a_o, gate_b_o, smp_avg_o, smp_bal1_o, smp_bal2_o, cmd_upd_o} == 6'b0,
        "R1 outputs in reset",
        int'({gate_a_o, gate_b_o, smp_avg_o, smp_bal1_o, smp_bal2_o, cmd_upd_o}), 0);
    rst = 1'b0;
    @(negedge clk);
    chk(cmd_upd_o == 1'b1, "R1 first update strobe", int'(cmd_upd_o), 1);
    pa = 0;
    pb = 0;
    for (int k = 0; k < 8; k++) begin
      ja = int'($urandom_range(0, 255));
      jb = int'($urandom_range(0, 255));
      run_period(pa, pb, ja, jb, dir_a[k], dir_b[k]);
      pa = dir_a[k];
      pb = dir_b[k];
    end
    for (int k = 0; k < 20; k++) begin
      ja = int'($urandom_range(0, 255));
      jb = int'($urandom_range(0, 255));
      na = int'($urandom_range(0, HP + 4));
      nb = int'($urandom_range(0, HP + 4));
      run_period(pa, pb, ja, jb, na, nb);
      pa = na;
      pb = nb;
    end
    run_period(pa, pb, 0, 0, 0, 0);
    finish_up();
  end
endmodule